// File: doc/BRIEF.md
# Dual-Channel Control Register Bank

This block is the host-facing register file for a compression engine and a decompression engine that run side by side. A host reaches all the registers through one 32-bit write-data bus, one 32-bit read-data bus and a 4-bit register address. The top address bit picks the half: 0 for the compression channel, 1 for the decompression channel. The low three bits pick a register within that half. Both halves have the same layout. Offset 0 is a command word whose bit 0 starts the engine. Offsets 1 and 2 hold the uncompressed and the compressed block size, and drive the engine directly. Offset 3 is a read-only CRC word that the engine loads. Offset 4 is a status word. Offsets 5 to 7 are empty.

Each engine signals the end of a block with a one-cycle done pulse and its CRC on the same cycle. The bank stores that CRC and sets a sticky done flag. The compression command word holds two extra controls. Bit 1 enables a self-test in which the decompression engine undoes the block being compressed. Bit 2 enables the interrupt. While the self-test is on, the bank compares the two stored CRCs once both channels have completed. A difference sets a sticky mismatch flag, and the interrupt pin reports that flag when the interrupt is enabled.

Top module: `dual_chan_regbank`

## Requirements
- R1: Address bit 3 selects the channel (0 compression, 1 decompression). Offsets 1 (uncompressed size) and 2 (compressed size) are 32-bit read/write registers, separate in each half. Each is also driven onto that channel's size output port.
- R2: Offsets 5, 6 and 7 in either half read as zero, and writes to them change no register.
- R3: Writing offset 0 with bit 0 set makes that channel's start output high for exactly the one cycle after the write edge; the other channel's start stays low. Bit 0 reads back as 0. Bits 31..1 of the written word read back unchanged.
- R4: Offset 3 is read-only. On a cycle with the channel's done input high, it loads that channel's CRC input. Host writes to offset 3 change nothing.
- R5: Status bit 0 (offset 4) is set by the channel's done pulse. It stays set until the host writes 1 to bit 0 of that status word. When both happen in the same cycle, the set wins.
- R6: While compression command bit 1 (test mode) is set, the two stored CRCs are compared in the cycle after both channels have recorded a done. This holds whether the dones come together or apart. The comparison is visible one clock edge after the last done is captured. A difference sets compression status bit 1 (offset 4 of the compression half), which is sticky and cleared by writing 1 to it. Equal CRCs, or test mode off, leave it clear.
- R7: The irq output is high exactly when compression status bit 1 is set and compression command bit 2 is set.
- R8: After synchronous reset every register reads zero, and the start outputs, size outputs and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 4 | Register address; bit 3 selects the channel |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| comp_start | output | 1 | One-cycle start pulse to the compression engine |
| comp_usize | output | 32 | Compression uncompressed block size |
| comp_csize | output | 32 | Compression compressed block size |
| comp_done | input | 1 | Compression engine block-complete pulse |
| comp_crc | input | 32 | Compression engine CRC, valid with `comp_done` |
| decomp_start | output | 1 | One-cycle start pulse to the decompression engine |
| decomp_usize | output | 32 | Decompression uncompressed block size |
| decomp_csize | output | 32 | Decompression compressed block size |
| decomp_done | input | 1 | Decompression engine block-complete pulse |
| decomp_crc | input | 32 | Decompression engine CRC, valid with `decomp_done` |
| irq | output | 1 | CRC mismatch interrupt |

## Verification
The register sweep writes a distinct word to every one of the 16 addresses and then reads all 16 back. This separates crossed halves, stray writes to the read-only and empty offsets, and start pulses sent to the wrong engine. Several CRC pairs go through the self-test: equal values, values that differ in one bit, dones arriving in the same cycle or in different cycles, and a differing pair with test mode off. Together these separate a correct compare from one that fires too early, ignores timing, or ignores the mode bit. The interrupt is then checked with the enable bit set and cleared while the flag is held, and again after the flag is cleared by a write.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int OFF_W  = ADDR_W - 1;
    localparam int N_CHAN = 2;

    localparam logic [OFF_W-1:0] OFF_CMD   = OFF_W'(0);
    localparam logic [OFF_W-1:0] OFF_USIZE = OFF_W'(1);
    localparam logic [OFF_W-1:0] OFF_CSIZE = OFF_W'(2);
    localparam logic [OFF_W-1:0] OFF_CRC   = OFF_W'(3);
    localparam logic [OFF_W-1:0] OFF_STAT  = OFF_W'(4);

    localparam int CMD_START_BIT = 0;
    localparam int CMD_TEST_BIT  = 1;
    localparam int CMD_IRQEN_BIT = 2;
    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_MISM_BIT = 1;

    localparam logic [DATA_W-1:0] CMD_START_MASK = DATA_W'(1) << CMD_START_BIT;

    typedef struct packed {
        logic [DATA_W-1:0] cmd;
        logic [DATA_W-1:0] usize;
        logic [DATA_W-1:0] csize;
        logic [DATA_W-1:0] crc;
        logic              done;
    } chan_regs_t;

    function automatic logic off_is_reserved(input logic [OFF_W-1:0] off);
        return off > OFF_STAT;
    endfunction
endpackage

// File: rtl/regbank_chan.sv
module regbank_chan
    import regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_crc,
    input  logic              seen_clr,
    output chan_regs_t        regs,
    output logic              start,
    output logic              seen,
    output logic [DATA_W-1:0] rd_word
);
    logic cmd_wr, stat_wr;

    assign cmd_wr  = wr_sel && (off == OFF_CMD);
    assign stat_wr = wr_sel && (off == OFF_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs  <= '0;
            start <= 1'b0;
            seen  <= 1'b0;
        end else begin
            start <= cmd_wr && wdata[CMD_START_BIT];
            if (cmd_wr)
                regs.cmd <= wdata & ~CMD_START_MASK;
            if (wr_sel && off == OFF_USIZE)
                regs.usize <= wdata;
            if (wr_sel && off == OFF_CSIZE)
                regs.csize <= wdata;
            if (eng_done)
                regs.crc <= eng_crc;
            if (eng_done)
                regs.done <= 1'b1;
            else if (stat_wr && wdata[STAT_DONE_BIT])
                regs.done <= 1'b0;
            seen <= eng_done || (seen && !seen_clr);
        end
    end

    always_comb begin
        rd_word = '0;
        if (!off_is_reserved(off)) begin
            case (off)
                OFF_CMD:   rd_word = regs.cmd;
                OFF_USIZE: rd_word = regs.usize;
                OFF_CSIZE: rd_word = regs.csize;
                OFF_CRC:   rd_word = regs.crc;
                default:   rd_word = DATA_W'(regs.done) << STAT_DONE_BIT;
            endcase
        end
    end
endmodule

// File: rtl/crc_mismatch_unit.sv
module crc_mismatch_unit
    import regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              test_en,
    input  logic              seen_a,
    input  logic              seen_b,
    input  logic [DATA_W-1:0] crc_a,
    input  logic [DATA_W-1:0] crc_b,
    input  logic              clr,
    output logic              fire,
    output logic              mism
);
    assign fire = seen_a && seen_b;

    always_ff @(posedge clk) begin
        if (rst)
            mism <= 1'b0;
        else if (fire && test_en && (crc_a != crc_b))
            mism <= 1'b1;
        else if (clr)
            mism <= 1'b0;
    end
endmodule

// File: rtl/dual_chan_regbank.sv
module dual_chan_regbank
    import regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              comp_start,
    output logic [DATA_W-1:0] comp_usize,
    output logic [DATA_W-1:0] comp_csize,
    input  logic              comp_done,
    input  logic [DATA_W-1:0] comp_crc,
    output logic              decomp_start,
    output logic [DATA_W-1:0] decomp_usize,
    output logic [DATA_W-1:0] decomp_csize,
    input  logic              decomp_done,
    input  logic [DATA_W-1:0] decomp_crc,
    output logic              irq
);
    logic              sel_half;
    logic [OFF_W-1:0]  off;
    chan_regs_t        regs    [N_CHAN];
    logic              start_v [N_CHAN];
    logic              seen_v  [N_CHAN];
    logic              done_v  [N_CHAN];
    logic [DATA_W-1:0] crc_in  [N_CHAN];
    logic [DATA_W-1:0] rd_v    [N_CHAN];
    logic              fire, mism_q, mism_clr;
    logic [DATA_W-1:0] comp_crc_q;

    assign sel_half = addr[ADDR_W-1];
    assign off      = addr[OFF_W-1:0];

    assign done_v[0] = comp_done;
    assign done_v[1] = decomp_done;
    assign crc_in[0] = comp_crc;
    assign crc_in[1] = decomp_crc;

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        regbank_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_sel   (wr_en && (sel_half == 1'(g))),
            .off      (off),
            .wdata    (wdata),
            .eng_done (done_v[g]),
            .eng_crc  (crc_in[g]),
            .seen_clr (fire),
            .regs     (regs[g]),
            .start    (start_v[g]),
            .seen     (seen_v[g]),
            .rd_word  (rd_v[g])
        );
    end

    assign mism_clr = wr_en && !sel_half && (off == OFF_STAT) && wdata[STAT_MISM_BIT];

    crc_mismatch_unit u_cmp (
        .clk     (clk),
        .rst     (rst),
        .test_en (regs[0].cmd[CMD_TEST_BIT]),
        .seen_a  (seen_v[0]),
        .seen_b  (seen_v[1]),
        .crc_a   (regs[0].crc),
        .crc_b   (regs[1].crc),
        .clr     (mism_clr),
        .fire    (fire),
        .mism    (mism_q)
    );

    always_comb begin
        rdata = rd_v[sel_half];
        if (!sel_half && off == OFF_STAT)
            rdata = rdata | (DATA_W'(mism_q) << STAT_MISM_BIT);
    end

    assign comp_crc_q   = regs[0].crc;
    assign comp_start   = start_v[0];
    assign decomp_start = start_v[1];
    assign comp_usize   = regs[0].usize;
    assign comp_csize   = regs[0].csize;
    assign decomp_usize = regs[1].usize;
    assign decomp_csize = regs[1].csize;
    assign irq          = mism_q && regs[0].cmd[CMD_IRQEN_BIT];
endmodule

// File: rtl/regbank_checker.sv
module regbank_checker
    import regbank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              comp_start,
    input logic              comp_done,
    input logic [DATA_W-1:0] comp_crc,
    input logic [DATA_W-1:0] crc_cap,
    input logic              mism,
    input logic              irq
);
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 4'h0 && wdata[0]) |=> comp_start); // R3
    AST_NO_SPURIOUS_START: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == 4'h0 && wdata[0]) |=> !comp_start); // R3
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr[2:0] > 3'd4) |-> (rdata == '0)); // R2
    AST_CRC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        comp_done |=> (crc_cap == $past(comp_crc))); // R4
    AST_MISM_STICKY: assert property (@(posedge clk) disable iff (rst)
        (mism && !(wr_en && addr == 4'h4 && wdata[1])) |=> mism); // R6
    AST_IRQ_NEEDS_MISM: assert property (@(posedge clk) disable iff (rst)
        irq |-> mism); // R7
endmodule

bind dual_chan_regbank regbank_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .comp_start (comp_start),
    .comp_done  (comp_done),
    .comp_crc   (comp_crc),
    .crc_cap    (comp_crc_q),
    .mism       (mism_q),
    .irq        (irq)
);

// File: tb/dual_chan_regbank_tb_top.sv
module dual_chan_regbank_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        comp_start, decomp_start, irq;
    logic [31:0] comp_usize, comp_csize, decomp_usize, decomp_csize;
    logic        comp_done = 1'b0, decomp_done = 1'b0;
    logic [31:0] comp_crc = '0, decomp_crc = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [31:0] model [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_chan_regbank dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .comp_start(comp_start), .comp_usize(comp_usize), .comp_csize(comp_csize),
        .comp_done(comp_done), .comp_crc(comp_crc),
        .decomp_start(decomp_start), .decomp_usize(decomp_usize), .decomp_csize(decomp_csize),
        .decomp_done(decomp_done), .decomp_crc(decomp_crc), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic pulse(input logic cd, input logic dd, input logic [31:0] ca, input logic [31:0] cb);
        @(negedge clk);
        comp_done = cd; decomp_done = dd; comp_crc = ca; decomp_crc = cb;
        @(negedge clk);
        comp_done = 1'b0; decomp_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8 reset state
        for (int a = 0; a < 16; a++) rd_chk("R8 reset read", 4'(a), 32'h0);
        check("R8 reset irq/start", {29'b0, irq, comp_start, decomp_start}, 32'h0);
        check("R8 reset size", comp_usize | comp_csize | decomp_usize | decomp_csize, 32'h0);

        // R1 R2 R3 R4 sweep over all 16 addresses
        for (int a = 0; a < 16; a++) begin
            logic [31:0] d;
            d = (32'hA5A5_0F00 ^ (32'(a) * 32'h0101_0101)) | 32'h1;
            if (a[2:0] == 3'd4) d = d & ~32'h3;
            if (a[2:0] == 3'd0) d = d & ~32'h6;
            wr(4'(a), d);
            check("R3 comp_start after write", {31'b0, comp_start}, {31'b0, a == 0});
            check("R3 decomp_start after write", {31'b0, decomp_start}, {31'b0, a == 8});
            case (a[2:0])
                3'd0:    model[a] = d & ~32'h1;
                3'd1,
                3'd2:    model[a] = d;
                default: model[a] = 32'h0;
            endcase
        end
        @(negedge clk);
        check("R3 start single cycle", {30'b0, comp_start, decomp_start}, 32'h0);
        for (int a = 0; a < 16; a++) rd_chk($sformatf("R1 R2 R4 readback addr %0d", a), 4'(a), model[a]);
        check("R1 comp_usize port", comp_usize, model[1]);
        check("R1 comp_csize port", comp_csize, model[2]);
        check("R1 decomp_usize port", decomp_usize, model[9]);
        check("R1 decomp_csize port", decomp_csize, model[10]);

        // R4 R5 capture and done flag, W1C
        wr(4'h0, 32'h0);
        wr(4'h8, 32'h0);
        pulse(1'b1, 1'b0, 32'h1111_2222, 32'h0);
        rd_chk("R4 comp crc captured", 4'h3, 32'h1111_2222);
        rd_chk("R5 comp done set", 4'h4, 32'h1);
        rd_chk("R5 decomp done clear", 4'hC, 32'h0);
        wr(4'h3, 32'hFFFF_FFFF);
        rd_chk("R4 crc write ignored", 4'h3, 32'h1111_2222);
        wr(4'h4, 32'h0);
        rd_chk("R5 write 0 keeps done", 4'h4, 32'h1);
        wr(4'h4, 32'h1);
        rd_chk("R5 W1C clears done", 4'h4, 32'h0);
        pulse(1'b0, 1'b1, 32'h0, 32'h3333_4444);
        rd_chk("R4 decomp crc captured", 4'hB, 32'h3333_4444);
        rd_chk("R5 decomp done set", 4'hC, 32'h1);
        // seen flags now both set with test off: no mismatch
        @(negedge clk);
        rd_chk("R6 test off no mismatch", 4'h4, 32'h0);
        wr(4'hC, 32'h1);

        // R6 test mode, equal CRCs same cycle
        wr(4'h0, 32'h6);
        rd_chk("R3 cmd readback", 4'h0, 32'h6);
        pulse(1'b1, 1'b1, 32'hCAFE_0001, 32'hCAFE_0001);
        @(negedge clk);
        rd_chk("R6 equal crc no mismatch", 4'h4, 32'h1);
        check("R7 irq low on equal", {31'b0, irq}, 32'h0);
        wr(4'h4, 32'h1);

        // R6 differing CRCs same cycle: visible one edge later
        pulse(1'b1, 1'b1, 32'hDEAD_0001, 32'hDEAD_0000);
        rd_chk("R6 mismatch not yet", 4'h4, 32'h1);
        @(negedge clk);
        rd_chk("R6 mismatch set", 4'h4, 32'h3);
        check("R7 irq high", {31'b0, irq}, 32'h1);
        wr(4'h0, 32'h2);
        check("R7 irq masked", {31'b0, irq}, 32'h0);
        rd_chk("R6 mismatch still held", 4'h4, 32'h3);
        wr(4'h0, 32'h6);
        check("R7 irq reenabled", {31'b0, irq}, 32'h1);
        wr(4'h4, 32'h1);
        rd_chk("R6 done-only W1C keeps mismatch", 4'h4, 32'h2);
        wr(4'h4, 32'h2);
        rd_chk("R6 W1C clears mismatch", 4'h4, 32'h0);
        check("R7 irq low after clear", {31'b0, irq}, 32'h0);

        // R6 dones apart
        pulse(1'b1, 1'b0, 32'h0000_8000, 32'h0);
        repeat (3) @(negedge clk);
        rd_chk("R6 one done no compare", 4'h4, 32'h1);
        pulse(1'b0, 1'b1, 32'h0, 32'h0000_8001);
        rd_chk("R6 apart not yet", 4'h4, 32'h1);
        @(negedge clk);
        rd_chk("R6 apart mismatch", 4'h4, 32'h3);
        check("R7 irq apart", {31'b0, irq}, 32'h1);
        wr(4'h4, 32'h3);

        // R6 test off with differing CRCs
        wr(4'h0, 32'h4);
        pulse(1'b1, 1'b1, 32'h1, 32'h2);
        @(negedge clk);
        rd_chk("R6 test off differing", 4'h4, 32'h1);
        check("R7 irq test off", {31'b0, irq}, 32'h0);

        // R8 reset again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_chk("R8 reset cmd", 4'h0, 32'h0);
        rd_chk("R8 reset crc", 4'h3, 32'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule